// File: doc/BRIEF.md
# Strap-Addressed MDIO Management Slave

This block is the serial management slave of a device that holds four PHY channels. It runs on the management clock and watches a shared bidirectional data line, split here into an input, an output and an output enable. It hunts for a run of ones, then decodes a start pattern, a read or write opcode, a 5-bit PHY address and a 5-bit register address. After a turnaround it either shifts 16 read bits out or collects 16 write bits.

The upper three bits of the PHY address act as a chip select. They are compared with a device number sampled from three strap inputs at the moment reset is released. The lower two bits pick one of four channels. Up to eight devices can therefore share a single management bus and present 32 PHYs.

Register storage sits outside the block. A one-cycle read strobe asks for a word, and that word must be valid on the read-data input by the next rising clock edge. A one-cycle write strobe delivers a word together with its channel and register number.

Top module: `mdio_strap_slave`

## Requirements
- R1: While reset is low and at the first clock after its release, `mdio_oe_o`, `rf_rd_o` and `rf_wr_o` are all 0.
- R2: The device number is the value of `strap_i` at the rising edge of `rst_ni`. Changes to `strap_i` after that edge have no effect until the next reset.
- R3: A frame is made of a preamble, then start bits 0,1, then opcode bits (10 = read, 01 = write). After the opcode come 5 PHY address bits and 5 register address bits, each sent MSB first. After them come 2 turnaround bits and 16 data bits, sent MSB first. Every bit is sampled on the rising edge of `mdc_i`.
- R4: On an accepted read, the slave leaves the line released during the first turnaround bit and drives 0 during the second. It then drives the 16 data bits MSB first. Each driven value changes just after a rising edge and is held for a whole clock. The line is released after the last data bit.
- R5: On an accepted read, `rf_rd_o` pulses for exactly one cycle, starting at the edge that samples the last register address bit. `rf_chan_o` and `rf_reg_o` are valid during the pulse, and `rf_rdata_i` is captured on the following edge.
- R6: On an accepted write, `rf_wr_o` pulses for one cycle after the edge that samples the 16th data bit. `rf_wdata_o`, `rf_chan_o` and `rf_reg_o` carry the received word and address during the pulse.
- R7: A frame is accepted only if PHY address bits 4:2 equal the device number. PHY address bits 1:0 give the channel on `rf_chan_o`.
- R8: A frame whose PHY address bits 4:2 differ from the device number never enables the output and never pulses either strobe. A later matching read returns the stored word unchanged.
- R9: At least 32 consecutive sampled ones must come before the start bits. With 31 the frame is ignored, and a longer run is accepted. Every frame needs its own preamble.
- R10: An opcode of 00 or 11 abandons the frame without any strobe or drive. The slave returns to preamble hunting, and the next well-formed frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its rising edge samples the straps |
| strap_i | input | 3 | Device number strap pins |
| mdio_i | input | 1 | Sampled management data line |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe_o | output | 1 | Output enable for the data line |
| rf_rd_o | output | 1 | Register read strobe |
| rf_wr_o | output | 1 | Register write strobe |
| rf_chan_o | output | 2 | Channel selected by the low PHY address bits |
| rf_reg_o | output | 5 | Register address |
| rf_wdata_o | output | 16 | Write data |
| rf_rdata_i | input | 16 | Read data, valid one cycle after the read strobe |

## Verification
The bench builds the block with its default parameters. These are a 16-bit data word, 5-bit PHY and register addresses, a 3-bit device number and a 32-bit preamble threshold. With these values a preamble of exactly 31 ones lies just below the threshold and one of 32 lies just at it, and all four channels and two different device numbers can be reached within one short run. Expected line drive, strobes, addresses and data are computed cycle by cycle from the frame the bench sends. That model is compared on every clock, including the turnaround cycles and the release after the last bit.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OPC,
    ST_ADDR,
    ST_TURN,
    ST_DATA
  } frame_st_e;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;
endpackage

// File: rtl/mdio_id_latch.sv
module mdio_id_latch #(
  parameter int ID_W = 3
) (
  input  logic            rst_ni,
  input  logic [ID_W-1:0] strap_i,
  output logic [ID_W-1:0] id_o
);
  // straps are sampled once, when reset is released
  always_ff @(posedge rst_ni) id_o <= strap_i;
endmodule

// File: rtl/mdio_pre_det.sv
module mdio_pre_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hunt_i,
  input  logic bit_i,
  output logic ready_o
);
  localparam int PC_W = $clog2(PRE_LEN + 1);
  localparam logic [PC_W-1:0] PC_TOP = PC_W'(PRE_LEN);

  logic [PC_W-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ones_q <= '0;
    else if (!hunt_i)       ones_q <= '0;
    else if (!bit_i)        ones_q <= '0;
    else if (ones_q != PC_TOP) ones_q <= ones_q + 1'b1;
  end

  assign ready_o = (ones_q == PC_TOP);

  // R9
  pre_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && hunt_i && bit_i) |=> ready_o);
endmodule

// File: rtl/mdio_rd_shift.sv
module mdio_rd_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ldata_i,
  input  logic              shift_i,
  input  logic              drop_i,
  output logic              mdio_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      oe_o   <= 1'b0;
      mdio_o <= 1'b0;
    end else if (load_i) begin
      // second turnaround bit is a driven zero
      sr_q   <= ldata_i;
      oe_o   <= 1'b1;
      mdio_o <= 1'b0;
    end else if (drop_i) begin
      oe_o   <= 1'b0;
      mdio_o <= 1'b0;
    end else if (shift_i) begin
      mdio_o <= sr_q[DATA_W-1];
      sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  // R4
  ta_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !mdio_o);
endmodule

// File: rtl/mdio_strap_slave.sv
module mdio_strap_slave
  import mdio_slave_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int ID_W    = 3,
  parameter int PRE_LEN = 32
) (
  input  logic                    mdc_i,
  input  logic                    rst_ni,
  input  logic [ID_W-1:0]         strap_i,
  input  logic                    mdio_i,
  output logic                    mdio_o,
  output logic                    mdio_oe_o,
  output logic                    rf_rd_o,
  output logic                    rf_wr_o,
  output logic [PHY_W-ID_W-1:0]   rf_chan_o,
  output logic [REG_W-1:0]        rf_reg_o,
  output logic [DATA_W-1:0]       rf_wdata_o,
  input  logic [DATA_W-1:0]       rf_rdata_i
);
  localparam int CHAN_W  = PHY_W - ID_W;
  localparam int ADDR_W  = PHY_W + REG_W;
  localparam int CNT_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX);

  frame_st_e          st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               op_hi_q, is_rd_q, hit_q;
  logic [ADDR_W-2:0]  addr_sr_q;
  logic [DATA_W-2:0]  wr_sr_q;
  logic [ID_W-1:0]    dev_id;
  logic               pre_ok;
  logic [ADDR_W-1:0]  addr_full;
  logic               id_hit, addr_last, data_last, rd_hit;
  logic               sh_load, sh_shift;

  mdio_id_latch #(.ID_W(ID_W)) u_id (
    .rst_ni (rst_ni),
    .strap_i(strap_i),
    .id_o   (dev_id)
  );

  mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk_i  (mdc_i),
    .rst_ni (rst_ni),
    .hunt_i (st_q == ST_HUNT),
    .bit_i  (mdio_i),
    .ready_o(pre_ok)
  );

  assign addr_full = {addr_sr_q, mdio_i};
  assign id_hit    = (addr_full[ADDR_W-1 -: ID_W] == dev_id);
  assign addr_last = (st_q == ST_ADDR) && (cnt_q == CNT_W'(ADDR_W - 1));
  assign data_last = (st_q == ST_DATA) && (cnt_q == CNT_W'(DATA_W - 1));
  assign rd_hit    = hit_q && is_rd_q;
  assign sh_load   = rd_hit && (st_q == ST_TURN) && (cnt_q == '0);
  assign sh_shift  = rd_hit && (((st_q == ST_TURN) && (cnt_q == CNT_W'(1))) ||
                                ((st_q == ST_DATA) && !data_last));

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      cnt_q      <= '0;
      op_hi_q    <= 1'b0;
      is_rd_q    <= 1'b0;
      hit_q      <= 1'b0;
      addr_sr_q  <= '0;
      wr_sr_q    <= '0;
      rf_rd_o    <= 1'b0;
      rf_wr_o    <= 1'b0;
      rf_chan_o  <= '0;
      rf_reg_o   <= '0;
      rf_wdata_o <= '0;
    end else begin
      rf_rd_o <= 1'b0;
      rf_wr_o <= 1'b0;
      unique case (st_q)
        ST_HUNT: if (!mdio_i && pre_ok) st_q <= ST_START;
        ST_START: begin
          cnt_q <= '0;
          st_q  <= mdio_i ? ST_OPC : ST_HUNT;
        end
        ST_OPC: begin
          if (cnt_q == '0) begin
            op_hi_q <= mdio_i;
            cnt_q   <= CNT_W'(1);
          end else begin
            cnt_q <= '0;
            if ({op_hi_q, mdio_i} == OPC_RD) begin
              is_rd_q <= 1'b1;
              st_q    <= ST_ADDR;
            end else if ({op_hi_q, mdio_i} == OPC_WR) begin
              is_rd_q <= 1'b0;
              st_q    <= ST_ADDR;
            end else begin
              st_q <= ST_HUNT;
            end
          end
        end
        ST_ADDR: begin
          addr_sr_q <= addr_full[ADDR_W-2:0];
          if (addr_last) begin
            cnt_q <= '0;
            st_q  <= ST_TURN;
            hit_q <= id_hit;
            if (id_hit) begin
              rf_chan_o <= addr_full[REG_W +: CHAN_W];
              rf_reg_o  <= addr_full[REG_W-1:0];
              rf_rd_o   <= is_rd_q;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TURN: begin
          if (cnt_q == '0) cnt_q <= CNT_W'(1);
          else begin
            cnt_q <= '0;
            st_q  <= ST_DATA;
          end
        end
        ST_DATA: begin
          wr_sr_q <= {wr_sr_q[DATA_W-3:0], mdio_i};
          if (data_last) begin
            cnt_q <= '0;
            st_q  <= ST_HUNT;
            if (hit_q && !is_rd_q) begin
              rf_wr_o    <= 1'b1;
              rf_wdata_o <= {wr_sr_q, mdio_i};
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  mdio_rd_shift #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (mdc_i),
    .rst_ni (rst_ni),
    .load_i (sh_load),
    .ldata_i(rf_rdata_i),
    .shift_i(sh_shift),
    .drop_i (data_last),
    .mdio_o (mdio_o),
    .oe_o   (mdio_oe_o)
  );

  // R5
  rd_pulse_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    rf_rd_o |=> !rf_rd_o);
  // R6
  wr_pulse_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    rf_wr_o |=> !rf_wr_o);
  // R6
  no_wr_while_drive_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    !(rf_wr_o && mdio_oe_o));
  // R4
  drive_after_fetch_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> $past(rf_rd_o));
endmodule

// File: tb/mdio_strap_slave_bench.sv
`timescale 1ns/1ps
module mdio_strap_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap = 3'b000;
  logic        mdio_in = 1'b0;
  logic        mdio_out, mdio_oe, rd, wr;
  logic [1:0]  chan;
  logic [4:0]  rreg;
  logic [15:0] wdata, rdata;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0]  dev_model;
  logic [15:0] rf_mem [4][32];
  int          model_mem [4][32];

  always #2 clk = ~clk;

  mdio_strap_slave u_mdio_strap_slave (
    .mdc_i(clk), .rst_ni(rst_n), .strap_i(strap), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .rf_rd_o(rd), .rf_wr_o(wr),
    .rf_chan_o(chan), .rf_reg_o(rreg), .rf_wdata_o(wdata), .rf_rdata_i(rdata)
  );

  assign rdata = rf_mem[chan][rreg];
  always @(posedge clk) if (wr) rf_mem[chan][rreg] <= wdata;

  task automatic chk(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic [2:0] s);
    rst_n = 1'b0;
    strap = s;
    mdio_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "oe in reset", int'(mdio_oe), 0);
    chk("R1", "rd in reset", int'(rd), 0);
    chk("R1", "wr in reset", int'(wr), 0);
    rst_n = 1'b1;
    dev_model = s;
    @(negedge clk);
    chk("R1", "oe after reset", int'(mdio_oe), 0);
    chk("R1", "wr after reset", int'(wr), 0);
    strap = ~s;  // later strap motion must not matter
  endtask

  task automatic frame(int pre, logic [1:0] op, logic [4:0] phy, logic [4:0] ra,
                       logic [15:0] wd, string tag);
    bit q[$];
    int len;
    logic valid, rdhit, wrhit, e_oe, e_rd, e_wr;
    logic [15:0] rdv;
    for (int i = 0; i < pre; i++) q.push_back(1'b1);
    q.push_back(1'b0); q.push_back(1'b1);
    q.push_back(op[1]); q.push_back(op[0]);
    for (int i = 4; i >= 0; i--) q.push_back(phy[i]);
    for (int i = 4; i >= 0; i--) q.push_back(ra[i]);
    if (op == 2'b01) begin
      q.push_back(1'b1); q.push_back(1'b0);
      for (int i = 15; i >= 0; i--) q.push_back(wd[i]);
    end else begin
      for (int i = 0; i < 18; i++) q.push_back(1'b1);  // released line
    end
    valid = (pre >= 32) && (op == 2'b10 || op == 2'b01);
    rdhit = valid && (phy[4:2] == dev_model) && (op == 2'b10);
    wrhit = valid && (phy[4:2] == dev_model) && (op == 2'b01);
    rdv   = 16'(model_mem[phy[1:0]][ra]);
    len   = q.size();
    for (int j = 0; j <= len; j++) begin
      @(negedge clk);
      e_oe = rdhit && (j >= pre + 15) && (j <= pre + 31);
      e_rd = rdhit && (j == pre + 14);
      e_wr = wrhit && (j == pre + 32);
      chk({"R4 ", tag}, "oe", int'(mdio_oe), int'(e_oe));
      if (e_oe)
        chk({"R4 ", tag}, "mdio", int'(mdio_out),
            (j == pre + 15) ? 0 : int'(rdv[15 - (j - pre - 16)]));
      chk({"R5 ", tag}, "rd", int'(rd), int'(e_rd));
      chk({"R6 ", tag}, "wr", int'(wr), int'(e_wr));
      if (e_rd || e_wr) begin
        chk({"R7 ", tag}, "chan", int'(chan), int'(phy[1:0]));
        chk({"R3 ", tag}, "reg", int'(rreg), int'(ra));
      end
      if (e_wr) chk({"R6 ", tag}, "wdata", int'(wdata), int'(wd));
      mdio_in = (j < len) ? q[j] : 1'b0;
    end
    if (wrhit) model_mem[phy[1:0]][ra] = int'(wd);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R3 watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 32; r++) begin
        rf_mem[c][r]    = 16'((c * 16'h1111) ^ (r * 16'h0307));
        model_mem[c][r] = int'(16'((c * 16'h1111) ^ (r * 16'h0307)));
      end

    do_reset(3'b101);
    // R3 basic write then read
    frame(32, 2'b01, {3'b101, 2'd2}, 5'd7, 16'hA5C3, "R3");
    frame(32, 2'b10, {3'b101, 2'd2}, 5'd7, 16'h0, "R3");
    // R7 all channels
    for (int c = 0; c < 4; c++)
      frame(32, 2'b01, {3'b101, 2'(c)}, 5'd3, 16'(16'h3C00 + c * 16'h0111), "R7");
    for (int c = 0; c < 4; c++)
      frame(32, 2'b10, {3'b101, 2'(c)}, 5'd3, 16'h0, "R7");
    // R9 long preamble accepted
    frame(40, 2'b01, {3'b101, 2'd1}, 5'd9, 16'h1234, "R9");
    frame(33, 2'b10, {3'b101, 2'd1}, 5'd9, 16'h0, "R9");
    // R8 foreign device number ignored
    frame(32, 2'b01, {3'b100, 2'd1}, 5'd9, 16'hFFFF, "R8");
    frame(32, 2'b10, {3'b001, 2'd1}, 5'd9, 16'h0, "R8");
    frame(32, 2'b10, {3'b101, 2'd1}, 5'd9, 16'h0, "R8");
    // R9 31-bit preamble ignored
    frame(31, 2'b01, {3'b101, 2'd1}, 5'd9, 16'h0000, "R9");
    frame(32, 2'b10, {3'b101, 2'd1}, 5'd9, 16'h0, "R9");
    // R10 bad opcodes abandon the frame
    frame(32, 2'b11, {3'b101, 2'd1}, 5'd9, 16'h0000, "R10");
    frame(32, 2'b00, {3'b101, 2'd1}, 5'd9, 16'h0000, "R10");
    frame(32, 2'b10, {3'b101, 2'd1}, 5'd9, 16'h0, "R10");
    // R2 new strap value after a second reset
    do_reset(3'b010);
    frame(32, 2'b01, {3'b010, 2'd3}, 5'd0, 16'h8001, "R2");
    frame(32, 2'b10, {3'b010, 2'd3}, 5'd0, 16'h0, "R2");
    frame(32, 2'b10, {3'b101, 2'd2}, 5'd7, 16'h0, "R2");
    frame(32, 2'b10, {3'b010, 2'd2}, 5'd7, 16'h0, "R2");
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule